// File: doc/BRIEF.md
# Set/clear clock gate controller

This block switches a bank of clock gates on and off. Each gate is one bit of a 32-bit word, and each drives its own gated copy of the input clock. Software never writes the enable state directly. Writing a word to the set register turns on every gate whose bit is one. Writing a word to the clear register turns off every gate whose bit is one. Gates whose bits are zero keep their state, so no read-modify-write is needed. A third register reports which gates are on.

The register bus is a plain synchronous port: address, write enable, write data and read data. Read data is registered. Each gate is held by a two-state machine, `GATE_OFF` and `GATE_ON`. The transition `OFF->ON` is taken on a set request with no clear request. The transition `ON->OFF` is taken on a clear request, and clear wins if both requests are present. The gate state feeds a cell that latches the enable while the clock is low and ANDs it with the clock. As a result, every change starts or stops the output on a whole clock pulse.

Top module: `clk_gate_bank`

## Requirements
- R1: While `rst_n` is low and after it is released, every gate is off, all `gclk` bits are low, and a status read returns 0.
- R2: A write to byte address 0x0 turns on each gate whose write-data bit is 1. Gates whose bit is 0 keep their state.
- R3: A write to byte address 0x4 turns off each gate whose write-data bit is 1. Gates whose bit is 0 keep their state. A write of zero changes nothing.
- R4: A read of address 0x8 returns bit i = 1 exactly when gate i is on. `rd_data` is registered. It shows, one cycle after the address is presented, the state at that clock edge.
- R5: Reads of addresses 0x0, 0x4 and of any unmapped address (anything other than 0x0, 0x4 or 0x8, including 0x1 and 0xC) return 0. Writes to 0x8 or to an unmapped address change no gate.
- R6: When gate i is on, `gclk[i]` follows `clk`. When it is off, `gclk[i]` stays low. A change written at one rising edge shows from the next rising edge onward. `gclk` never rises or falls except together with `clk`, so no pulse is ever cut short.
- R7: Write-data bits at positions `N_GATES` and above are ignored, and status bits at those positions read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the source of every gated clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; a 1 marks a gate to set or clear |
| rd_data | output | 32 | Registered read data for the address of the previous cycle |
| gclk | output | N_GATES | One gated clock per gate |

## Verification
A gate whose state machine sits in the wrong state is visible at two ports within one cycle. The status word read back one cycle after address 0x8 is presented shows the wrong bit. The matching `gclk` bit pulses, or stays silent, from the very next rising edge. A faulty enable latch does not show in the state at all: it shows only as a `gclk` edge that does not coincide with a `clk` edge. For that reason, every change on `gclk` is compared against the clock level at the moment it happens.

// File: rtl/cgb_pkg.sv
package cgb_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned OFS_SET  = 32'h0;
    localparam int unsigned OFS_CLR  = 32'h4;
    localparam int unsigned OFS_STAT = 32'h8;

    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_STAT = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/cgb_regif.sv
module cgb_regif
    import cgb_pkg::*;
#(
    parameter int unsigned N_GATES = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wen,
    input  logic [REG_W-1:0]    bus_wdata,
    input  logic [N_GATES-1:0]  gate_on,
    output logic [N_GATES-1:0]  set_req,
    output logic [N_GATES-1:0]  clr_req,
    output logic [REG_W-1:0]    rd_data
);

    acc_kind_e kind;

    // address decode: full compare, anything else is unmapped
    always_comb begin
        if (bus_addr == ADDR_W'(OFS_SET))
            kind = ACC_SET;
        else if (bus_addr == ADDR_W'(OFS_CLR))
            kind = ACC_CLR;
        else if (bus_addr == ADDR_W'(OFS_STAT))
            kind = ACC_STAT;
        else
            kind = ACC_NONE;
    end

    // bits above the gate count are simply not taken
    always_comb begin
        set_req = '0;
        clr_req = '0;
        if (bus_wen) begin
            unique case (kind)
                ACC_SET:  set_req = bus_wdata[N_GATES-1:0];
                ACC_CLR:  clr_req = bus_wdata[N_GATES-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '0;
        else if (kind == ACC_STAT)
            rd_data <= REG_W'(gate_on);
        else
            rd_data <= '0;
    end

endmodule

// File: rtl/cgb_gate_fsm.sv
module cgb_gate_fsm
    import cgb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic on
);

    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: if (set_req && !clr_req) state_d = GATE_ON;
            GATE_ON:  if (clr_req)             state_d = GATE_OFF;
            default:                           state_d = GATE_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= GATE_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        on = (state_q == GATE_ON);
    end

endmodule

// File: rtl/cgb_clk_cell.sv
module cgb_clk_cell (
    input  logic clk,
    input  logic en,
    output logic gclk
);

    logic en_lat;

    // enable passes only in the low phase, held through the high phase
    always_latch begin
        if (!clk)
            en_lat = en;
    end

    assign gclk = clk & en_lat;

endmodule

// File: rtl/clk_gate_bank.sv
module clk_gate_bank
    import cgb_pkg::*;
#(
    parameter int unsigned N_GATES = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wen,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         rd_data,
    output logic [N_GATES-1:0]  gclk
);

    logic [N_GATES-1:0] set_req;
    logic [N_GATES-1:0] clr_req;
    logic [N_GATES-1:0] gate_on;

    cgb_regif #(
        .N_GATES (N_GATES),
        .ADDR_W  (ADDR_W)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .gate_on   (gate_on),
        .set_req   (set_req),
        .clr_req   (clr_req),
        .rd_data   (rd_data)
    );

    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        cgb_gate_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_req[g]),
            .clr_req (clr_req[g]),
            .on      (gate_on[g])
        );
        cgb_clk_cell u_cell (
            .clk  (clk),
            .en   (gate_on[g]),
            .gclk (gclk[g])
        );
    end

endmodule

// File: rtl/cgb_chk.sv
module cgb_chk #(
    parameter int unsigned N_GATES = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wen,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        rd_data,
    input logic [N_GATES-1:0] gate_on
);

    logic is_set, is_clr, is_stat;
    assign is_set  = (bus_addr == ADDR_W'(32'h0));
    assign is_clr  = (bus_addr == ADDR_W'(32'h4));
    assign is_stat = (bus_addr == ADDR_W'(32'h8));

    // R1
    rst_off_chk: assert property (@(posedge clk) !rst_n |-> gate_on == '0);

    // R2
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && is_set) |=> ((gate_on & $past(bus_wdata[N_GATES-1:0])) == $past(bus_wdata[N_GATES-1:0])));

    // R3
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && is_clr) |=> ((gate_on & $past(bus_wdata[N_GATES-1:0])) == '0));

    // R5
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wen && (is_set || is_clr)) |=> $stable(gate_on));

    // R4
    stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_stat |=> rd_data == 32'($past(gate_on)));

    // R5
    other_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_stat |=> rd_data == 32'h0);

endmodule

bind clk_gate_bank cgb_chk #(
    .N_GATES (N_GATES),
    .ADDR_W  (ADDR_W)
) u_cgb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .gate_on   (gate_on)
);

// File: tb/tb_clk_gate_bank.sv
`timescale 1ns/1ps
module tb_clk_gate_bank;

    localparam int unsigned TB_N   = 20;
    localparam int unsigned TB_AW  = 8;
    localparam logic [31:0] TB_MSK = 32'h000F_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TB_AW-1:0]  bus_addr = 8'hFC;
    logic              bus_wen = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       rd_data;
    logic [TB_N-1:0]   gclk;

    clk_gate_bank #(.N_GATES(TB_N), .ADDR_W(TB_AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .gclk(gclk)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int glitches = 0;
    bit done = 0;
    logic [TB_N-1:0] mdl = '0;

    typedef struct {
        logic [31:0] exp;
        int          due;
        string       tag;
    } rd_item_t;
    rd_item_t scb[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare reads when they come due
    always @(negedge clk) begin
        while (scb.size() > 0 && scb[0].due == cyc) begin
            check(scb[0].tag, rd_data, scb[0].exp);
            void'(scb.pop_front());
        end
    end

    // R6 edge monitor: gclk may only move together with clk
    logic [TB_N-1:0] gprev = '0;
    always @(gclk) begin
        for (int i = 0; i < TB_N; i++) begin
            if (gprev[i] === 1'b0 && gclk[i] === 1'b1 && clk !== 1'b1) glitches++;
            if (gprev[i] === 1'b1 && gclk[i] === 1'b0 && clk !== 1'b0) glitches++;
        end
        gprev = gclk;
    end

    // driver tasks, each entered at a negedge and leaving at the next
    task automatic wr(input logic [TB_AW-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        if (a == 8'h0) mdl = mdl | d[TB_N-1:0];
        else if (a == 8'h4) mdl = mdl & ~d[TB_N-1:0];
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = 8'hFC;
    endtask

    task automatic rd(input logic [TB_AW-1:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        bus_addr = a; bus_wen = 1'b0;
        it.exp = exp; it.due = cyc + 1; it.tag = tag;
        scb.push_back(it);
        @(negedge clk);
        bus_addr = 8'hFC;
    endtask

    task automatic rd_stat(input string tag);
        rd(8'h8, 32'(mdl), tag);
    endtask

    task automatic gclk_chk(input string tag, input logic [TB_N-1:0] exp);
        @(posedge clk); #1;
        check({tag, " high"}, 32'(gclk), 32'(exp));
        @(negedge clk); #1;
        check({tag, " low"}, 32'(gclk), 32'h0);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        gclk_chk("R1 gclk in reset", '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_stat("R1 status after reset");
        gclk_chk("R1 gclk after reset", '0);

        wr(8'h0, 32'h0000_0005);
        gclk_chk("R6 gclk after set", mdl);
        rd_stat("R2 set 0x5");
        wr(8'h0, 32'h0000_0010);
        rd_stat("R2 zeros keep state");
        wr(8'h4, 32'h0000_0001);
        gclk_chk("R6 gclk after clear", mdl);
        rd_stat("R3 clear bit0");
        wr(8'h4, 32'h0);
        rd_stat("R3 zero clear word");
        rd(8'h8, 32'h0000_0014, "R4 status value 0x14");

        rd(8'h0, 32'h0, "R5 read set reg");
        rd(8'h4, 32'h0, "R5 read clear reg");
        rd(8'h1, 32'h0, "R5 read 0x1");
        rd(8'hC, 32'h0, "R5 read 0xC");
        wr(8'h8, 32'hFFFF_FFFF);
        rd_stat("R5 write status ignored");
        wr(8'hC, 32'hFFFF_FFFF);
        wr(8'h1, 32'hFFFF_FFFF);
        rd_stat("R5 unmapped write ignored");

        wr(8'h0, 32'hFFFF_FFFF);
        rd(8'h8, TB_MSK, "R7 upper set bits ignored");
        gclk_chk("R6 all gates on", mdl);
        wr(8'h4, 32'hFFF0_0000);
        rd(8'h8, TB_MSK, "R7 upper clear bits ignored");
        wr(8'h4, 32'h000A_5A5A);
        rd_stat("R4 mixed pattern");
        gclk_chk("R6 mixed pattern", mdl);

        rst_n = 1'b0;
        mdl = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_stat("R1 status after second reset");
        gclk_chk("R1 gclk after second reset", '0);
        wr(8'h4, 32'hFFFF_FFFF);
        rd_stat("R3 clear on all-off bank");

        repeat (3) @(negedge clk);
        check("R6 gclk edges aligned to clk", 32'(glitches), 32'h0);
        check("R4 scoreboard drained", 32'(scb.size()), 32'h0);
        finish_run();
    end

endmodule